// File: doc/BRIEF.md
# Write-to-Command Spacing Guard for a DDR3 Command Path

The guard sits in a memory controller's command path. On each cycle it decides whether the presented candidate command may be issued to the device. The candidate is an activate, write, read or precharge aimed at one bank. The guard keeps a small amount of state for each bank: whether its row is open, whether an automatic precharge is armed or running, and when the bank's most recent write burst finishes. It also keeps two device-wide counters, one for write-to-write spacing and one for write-to-read spacing.

A granted write does not constrain later commands from the cycle it is issued. The constraint runs from the cycle its data burst ends. That end point is the write latency (additive latency plus CAS write latency) plus the burst duration on the bus. A full eight-beat burst lasts four clocks and a chopped four-beat burst lasts two. The burst mode is either fixed by configuration or chosen per command. The guard answers with a combinational grant for the presented command. It also raises a per-bank pulse in the cycle an automatic precharge begins. The requester keeps a refused command presented until it is granted. The configuration inputs are held stable between resets.

Top module: `wr_guard`

## Requirements
- R1: After reset every bank is closed, no automatic precharge is pending and `ap_start` is all zero. A write or read presented before any activate is refused.
- R2: An activate (`cmd_type` 3) is granted only to a closed bank that has no automatic precharge armed or running. A granted activate opens the bank.
- R3: A write (`cmd_type` 0) or a read (`cmd_type` 1) is granted only to an open bank that has no automatic precharge armed or running.
- R4: Two granted writes are at least `TCCD` cycles apart, whatever banks they target. Back-to-back writes at exactly `TCCD` are granted.
- R5: The burst end of a write granted in cycle t is t + AL + CWL + 4 for an eight-beat burst, or t + AL + CWL + 2 for a chopped burst. `cfg_burst` 0 forces eight-beat bursts. `cfg_burst` 1 forces chopped bursts. `cfg_burst` 2 or 3 takes the choice from `cmd_chop` (1 = chopped).
- R6: A read to any bank is granted no earlier than the latest write burst end plus `TWTR`.
- R7: A precharge (`cmd_type` 2) to a bank is granted no earlier than that bank's latest write burst end plus `TWR`. A granted precharge closes the bank.
- R8: A write granted with `cmd_ap` set raises `ap_start[bank]` for exactly one cycle, at that write's burst end plus `TWR`, and closes the bank. Every command to that bank is refused from the write's grant until `TRP` cycles after the pulse.
- R9: `cmd_grant` is asserted only in a cycle where `cmd_valid` is high and every rule above allows the presented command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | CFGW | Additive latency in clocks |
| cfg_cwl | input | CFGW | CAS write latency in clocks |
| cfg_burst | input | 2 | Burst mode: 0 eight-beat, 1 chopped, 2/3 per command |
| cmd_valid | input | 1 | A candidate command is presented |
| cmd_type | input | 2 | 0 write, 1 read, 2 precharge, 3 activate |
| cmd_bank | input | BW | Target bank |
| cmd_ap | input | 1 | Write with automatic precharge |
| cmd_chop | input | 1 | Chopped burst when the mode is per command |
| cmd_grant | output | 1 | The presented command may issue this cycle |
| ap_start | output | NBANK | Per-bank pulse: automatic precharge begins |

## Verification
The hardest situation to reach from the ports is a command to a bank whose automatic precharge is armed but has not yet fired. It is hardest when that overlaps a chopped write on another bank, which moves the device-wide read window earlier than an eight-beat write would. Random stimulus reaches it by setting the auto-precharge flag on about a third of the writes and spreading the commands over few banks. It also runs a phase in each burst mode, including per-command chopping. Whenever the requester's own model sees a pending precharge, it turns the next command for that bank into an activate, so the command waits through the whole busy window. Directed cases cover a write refused right after reset and a read tried in every cycle until its exact release cycle after a chopped burst.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    typedef enum logic [1:0] {
        CMD_WR  = 2'd0,
        CMD_RD  = 2'd1,
        CMD_PRE = 2'd2,
        CMD_ACT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BM_FULL  = 2'd0,
        BM_CHOP  = 2'd1,
        BM_PICK  = 2'd2,
        BM_PICK2 = 2'd3
    } burst_e;

endpackage

// File: rtl/wr_guard_span.sv
module wr_guard_span #(
    parameter int CFGW = 4,
    parameter int SPW  = 6
) (
    input  logic [CFGW-1:0] al,
    input  logic [CFGW-1:0] cwl,
    input  logic [1:0]      mode,
    input  logic            chop_req,
    output logic [SPW-1:0]  span
);
    import wr_guard_pkg::*;

    logic chop;

    always_comb begin
        chop = (burst_e'(mode) == BM_CHOP) || (mode[1] && chop_req);
        span = SPW'(al) + SPW'(cwl) + (chop ? SPW'(2) : SPW'(4));
    end
endmodule

// File: rtl/wr_guard_bank.sv
module wr_guard_bank #(
    parameter int TWR  = 10,
    parameter int TRP  = 4,
    parameter int SPW  = 6,
    parameter int CNTW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic [1:0]     op,
    input  logic           ap_req,
    input  logic [SPW-1:0] span,
    output logic           is_open,
    output logic           busy,
    output logic           pre_ok,
    output logic           ap_fire
);
    import wr_guard_pkg::*;

    typedef struct packed {
        logic            open;
        logic            ap_arm;
        logic [CNTW-1:0] wr_cnt;
        logic [CNTW-1:0] rp_cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [CNTW-1:0] wr_new, wr_dec;

    always_comb begin
        is_open = st_q.open;
        busy    = st_q.ap_arm || (st_q.rp_cnt != '0);
        pre_ok  = (st_q.wr_cnt == '0);
        ap_fire = st_q.ap_arm && (st_q.wr_cnt == '0);

        st_d   = st_q;
        wr_dec = (st_q.wr_cnt == '0) ? '0 : st_q.wr_cnt - CNTW'(1);
        wr_new = CNTW'(span) + CNTW'(TWR - 1);
        st_d.wr_cnt = wr_dec;
        st_d.rp_cnt = (st_q.rp_cnt == '0) ? '0 : st_q.rp_cnt - CNTW'(1);

        if (ap_fire) begin
            st_d.ap_arm = 1'b0;
            st_d.open   = 1'b0;
            st_d.rp_cnt = CNTW'(TRP - 1);
        end

        if (sel) begin
            case (cmd_e'(op))
                CMD_WR: begin
                    st_d.wr_cnt = (wr_new > wr_dec) ? wr_new : wr_dec;
                    if (ap_req) st_d.ap_arm = 1'b1;
                end
                CMD_PRE: st_d.open = 1'b0;
                CMD_ACT: st_d.open = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
    parameter int NBANK = 8,
    parameter int CFGW  = 4,
    parameter int TCCD  = 4,
    parameter int TWTR  = 4,
    parameter int TWR   = 10,
    parameter int TRP   = 4,
    localparam int BW   = $clog2(NBANK),
    localparam int SPW  = CFGW + 2,
    localparam int MAXT = (TWR > TWTR) ? ((TWR > TCCD) ? TWR : TCCD) : ((TWTR > TCCD) ? TWTR : TCCD),
    localparam int CNTW = $clog2((1 << SPW) + MAXT + TRP + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFGW-1:0]  cfg_al,
    input  logic [CFGW-1:0]  cfg_cwl,
    input  logic [1:0]       cfg_burst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_type,
    input  logic [BW-1:0]    cmd_bank,
    input  logic             cmd_ap,
    input  logic             cmd_chop,
    output logic             cmd_grant,
    output logic [NBANK-1:0] ap_start
);
    import wr_guard_pkg::*;

    typedef struct packed {
        logic [CNTW-1:0] ccd_cnt;
        logic [CNTW-1:0] wtr_cnt;
    } glob_st_t;

    glob_st_t g_d, g_q;
    logic [SPW-1:0]   span;
    logic [NBANK-1:0] b_open, b_busy, b_pre_ok;
    logic             allow;
    logic [CNTW-1:0]  wtr_new, wtr_dec;

    wr_guard_span #(.CFGW(CFGW), .SPW(SPW)) u_span (
        .al(cfg_al), .cwl(cfg_cwl), .mode(cfg_burst),
        .chop_req(cmd_chop), .span(span)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        wr_guard_bank #(.TWR(TWR), .TRP(TRP), .SPW(SPW), .CNTW(CNTW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .sel(cmd_grant && (cmd_bank == BW'(i))),
            .op(cmd_type), .ap_req(cmd_ap), .span(span),
            .is_open(b_open[i]), .busy(b_busy[i]),
            .pre_ok(b_pre_ok[i]), .ap_fire(ap_start[i])
        );
    end

    always_comb begin
        case (cmd_e'(cmd_type))
            CMD_WR:  allow = b_open[cmd_bank] && !b_busy[cmd_bank] && (g_q.ccd_cnt == '0);
            CMD_RD:  allow = b_open[cmd_bank] && !b_busy[cmd_bank] && (g_q.wtr_cnt == '0);
            CMD_PRE: allow = !b_busy[cmd_bank] && b_pre_ok[cmd_bank];
            default: allow = !b_open[cmd_bank] && !b_busy[cmd_bank];
        endcase
        cmd_grant = cmd_valid && allow;

        g_d         = g_q;
        g_d.ccd_cnt = (g_q.ccd_cnt == '0) ? '0 : g_q.ccd_cnt - CNTW'(1);
        wtr_dec     = (g_q.wtr_cnt == '0) ? '0 : g_q.wtr_cnt - CNTW'(1);
        wtr_new     = CNTW'(span) + CNTW'(TWTR - 1);
        g_d.wtr_cnt = wtr_dec;
        if (cmd_grant && cmd_e'(cmd_type) == CMD_WR) begin
            g_d.ccd_cnt = CNTW'(TCCD - 1);
            g_d.wtr_cnt = (wtr_new > wtr_dec) ? wtr_new : wtr_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk #(
    parameter int NBANK = 8,
    parameter int BW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_grant,
    input logic [1:0]       cmd_type,
    input logic [BW-1:0]    cmd_bank,
    input logic [NBANK-1:0] ap_start
);
    logic wr_g, rd_g, pre_g, act_g;
    assign wr_g  = cmd_grant && cmd_type == 2'd0;
    assign rd_g  = cmd_grant && cmd_type == 2'd1;
    assign pre_g = cmd_grant && cmd_type == 2'd2;
    assign act_g = cmd_grant && cmd_type == 2'd3;

    // R4
    wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_g |=> !wr_g);

    // R6
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_g |=> !rd_g);

    // R7
    pre_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_g |=> !(pre_g && cmd_bank == $past(cmd_bank)));

    // R2
    act_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_g |=> !(act_g && cmd_bank == $past(cmd_bank)));

    for (genvar i = 0; i < NBANK; i++) begin : g_ap
        // R8
        ap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ap_start[i] |=> !ap_start[i]);
        // R8
        ap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ap_start[i] |-> !(cmd_grant && cmd_bank == BW'(i)));
    end
endmodule

bind wr_guard wr_guard_chk #(.NBANK(NBANK), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_grant(cmd_grant),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .ap_start(ap_start)
);

// File: tb/wr_guard_bench.sv
module wr_guard_bench;
    localparam int NBANK = 8;
    localparam int BW    = 3;
    localparam int TCCD  = 4;
    localparam int TWTR  = 4;
    localparam int TWR   = 10;
    localparam int TRP   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_al = '0, cfg_cwl = 4'd5;
    logic [1:0] cfg_burst = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_type = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic cmd_ap = 1'b0, cmd_chop = 1'b0;
    logic cmd_grant;
    logic [NBANK-1:0] ap_start;

    int checks = 0, errors = 0, cyc = 0;
    bit wd_hit = 0;

    // requester-side model
    int last_wr, rd_ok;
    int pre_ok[NBANK], ap_st[NBANK], ap_done[NBANK];
    bit open_b[NBANK], ap_arm[NBANK];

    always #5 clk = ~clk;

    wr_guard u_wr_guard (
        .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl),
        .cfg_burst(cfg_burst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_chop(cmd_chop),
        .cmd_grant(cmd_grant), .ap_start(ap_start)
    );

    function automatic int span_of(input bit ch);
        bit c = (cfg_burst == 2'd1) || (cfg_burst[1] && ch);
        return int'(cfg_al) + int'(cfg_cwl) + (c ? 2 : 4);
    endfunction

    function automatic bit exp_grant();
        int b = int'(cmd_bank);
        bit blk = ap_arm[b] || (cyc < ap_done[b]);
        if (!cmd_valid) return 0;
        case (cmd_type)
            2'd0: return open_b[b] && !blk && (cyc >= last_wr + TCCD);
            2'd1: return open_b[b] && !blk && (cyc >= rd_ok);
            2'd2: return !blk && (cyc >= pre_ok[b]);
            default: return !open_b[b] && !blk;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] t);
        case (t)
            2'd0: return "R4/R3/R9 write";
            2'd1: return "R6/R3/R5 read";
            2'd2: return "R7/R5 precharge";
            default: return "R2 activate";
        endcase
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // one cycle: compare outputs against the model, then advance the model
    task automatic step(output bit granted);
        logic [NBANK-1:0] exp_ap = '0;
        bit eg;
        #1;
        for (int i = 0; i < NBANK; i++) if (ap_arm[i] && cyc == ap_st[i]) exp_ap[i] = 1'b1;
        eg = exp_grant();
        check(cmd_grant == eg, req_of(cmd_type), int'(cmd_grant), int'(eg));
        check(ap_start == exp_ap, "R8 ap_start", int'(ap_start), int'(exp_ap));
        for (int i = 0; i < NBANK; i++)
            if (exp_ap[i]) begin
                ap_arm[i] = 0; open_b[i] = 0; ap_done[i] = ap_st[i] + TRP;
            end
        if (eg) begin
            int b = int'(cmd_bank);
            case (cmd_type)
                2'd0: begin
                    int e = cyc + span_of(cmd_chop);
                    last_wr = cyc;
                    if (e + TWTR > rd_ok) rd_ok = e + TWTR;
                    if (e + TWR > pre_ok[b]) pre_ok[b] = e + TWR;
                    if (cmd_ap) begin ap_arm[b] = 1; ap_st[b] = e + TWR; end
                end
                2'd2: open_b[b] = 0;
                2'd3: open_b[b] = 1;
                default: ;
            endcase
        end
        granted = eg;
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset(input int al, input int cwl, input int mode);
        rst_n = 0; cmd_valid = 0;
        cfg_al = 4'(al); cfg_cwl = 4'(cwl); cfg_burst = 2'(mode);
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc = 0; last_wr = -1000; rd_ok = 0;
        for (int i = 0; i < NBANK; i++) begin
            pre_ok[i] = 0; ap_st[i] = 0; ap_done[i] = 0; open_b[i] = 0; ap_arm[i] = 0;
        end
    endtask

    // present one command and hold it until granted
    task automatic issue(input logic [1:0] t, input int b, input bit ap, input bit ch);
        bit g = 0;
        int w = 0;
        cmd_valid = 1; cmd_type = t; cmd_bank = BW'(b); cmd_ap = ap; cmd_chop = ch;
        while (!g && !wd_hit) begin
            step(g);
            w++;
            if (w > 400) begin
                wd_hit = 1;
                check(0, "watchdog", w, 0);
            end
        end
        cmd_valid = 0;
    endtask

    initial begin
        bit g;
        int ph_al[4]  = '{0, 2, 1, 3};
        int ph_cwl[4] = '{5, 6, 8, 5};
        void'($urandom(32'h5eed_1234));
        @(negedge clk);

        // R1: reset state, write to a closed bank is refused
        do_reset(0, 5, 0);
        #1;
        check(ap_start == '0, "R1 ap_start after reset", int'(ap_start), 0);
        cmd_valid = 1; cmd_type = 2'd0; cmd_bank = '0;
        #1;
        check(cmd_grant == 1'b0, "R1 write before activate", int'(cmd_grant), 0);
        cmd_type = 2'd1;
        #1;
        check(cmd_grant == 1'b0, "R1 read before activate", int'(cmd_grant), 0);
        cmd_valid = 0;
        @(negedge clk); cyc++;

        // directed: chopped write then read released at exact window (R5, R6)
        do_reset(1, 5, 2);
        issue(2'd3, 2, 0, 0);
        issue(2'd0, 2, 0, 1);
        issue(2'd1, 2, 0, 0);
        check(cyc - 1 == last_wr + 6 + 2 + TWTR, "R5 chopped read release",
              cyc - 1, last_wr + 6 + 2 + TWTR);
        // back-to-back writes at TCCD (R4)
        issue(2'd0, 2, 0, 0);
        issue(2'd0, 2, 1, 0);
        check(cyc - 1 == last_wr, "R4 write issued", cyc - 1, last_wr);
        // command to bank while auto precharge pending (R8)
        issue(2'd3, 2, 0, 0);
        check(cyc - 1 == ap_done[2], "R8 activate after auto precharge", cyc - 1, ap_done[2]);

        // random phases, one per burst mode
        for (int ph = 0; ph < 4 && !wd_hit; ph++) begin
            do_reset(ph_al[ph], ph_cwl[ph], ph);
            for (int n = 0; n < 500 && !wd_hit; n++) begin
                int b = int'($urandom_range(0, 3));
                logic [1:0] t;
                if (!open_b[b] || ap_arm[b]) t = 2'd3;
                else t = 2'($urandom_range(0, 2));
                issue(t, b, ($urandom_range(0, 2) == 0), $urandom_range(0, 1) == 1);
                for (int k = $urandom_range(0, 2); k > 0; k--) step(g);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule